// File: doc/BRIEF.md
# Microstep Position Translator

This block turns step pulses into an electrical position for a two-phase stepper motor. It also produces the signed current magnitudes that the two coils should carry at that position. The position is held at 1/16-step resolution as a 6-bit count. The 64 counts cover one electrical cycle. Each rising edge on the step input moves the count by the increment of the selected step mode. The direction and the run/hold state each come from a pin combined by XOR with a control bit.

When the step mode changes, the position is snapped onto the grid of the new mode. Moving to a coarser mode clears the low position bits that the new mode cannot express. Moving to a finer mode keeps the position as it is, which amounts to appending zero bits below it. Coil X follows the cosine of the position and coil Y follows the sine. Both are looked up in a quarter-wave table of 8-bit magnitudes, and each coil has its own sign flag.

Top module: `stepper_xlat`

## Requirements
- R1: Reset (active-low `rst_n`) puts the position at 8, which is 45 degrees. Both magnitudes are then 180 and both sign flags are 0.
- R2: `mode` codes 0, 1, 2, 3 and 4 select full, half, quarter, eighth and sixteenth step, with increments of 16, 8, 4, 2 and 1. Code 5 is a half step with increment 8. Codes 6 and 7 act as sixteenth step.
- R3: The effective direction is `dir_pin ^ dir_inv`. A value of 1 adds the increment and a value of 0 subtracts it. The position wraps modulo 64.
- R4: `step_in` passes through a two-flop synchronizer. Only a rising edge acts. The position changes on the third rising clock edge after `step_in` goes high, and it moves once for each rising edge however long the input stays high.
- R5: When a coarser mode is selected, the low position bits below its increment are cleared on the next clock edge.
- R6: When a finer mode is selected, the position is left unchanged.
- R7: When `run_pin ^ run_inv` is 0 (hold), step edges are ignored and the position stays where it is.
- R8: For position p, `x_mag` equals round(255·|cos(2πp/64)|) and `y_mag` equals round(255·|sin(2πp/64)|).
- R9: `x_neg` is 1 exactly when cos(2πp/64) is negative. `y_neg` is 1 exactly when sin(2πp/64) is negative. A zero magnitude is never flagged negative.
- R10: In mode 1 (compensated half step), both magnitudes are 255 at positions where p mod 16 = 8. Mode 5 and all other modes use the plain table values at those positions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 3 | Step mode code |
| dir_pin | input | 1 | Direction pin |
| dir_inv | input | 1 | Direction control bit, XORed with the pin |
| run_pin | input | 1 | Run/hold pin |
| run_inv | input | 1 | Run/hold control bit, XORed with the pin |
| step_in | input | 1 | Asynchronous step pulse |
| pos | output | 6 | Position in sixteenth steps |
| x_mag | output | 8 | Coil X current magnitude |
| x_neg | output | 1 | Coil X negative |
| y_mag | output | 8 | Coil Y current magnitude |
| y_neg | output | 1 | Coil Y negative |

## Verification
The hardest case to reach from the ports is a mode change made while the position sits off the grid of the new mode. That happens after several fine steps followed by a switch to full or half step, especially near the wrap point. Random runs change the mode on about one step in eight and draw the new code from all eight values, including the aliased codes. This places coarsening changes at many odd positions. Directed steps add a coarsening from position 9, a wrap downward in full step, and the half-step diagonal in both half-step variants.

// File: rtl/stepper_xlat.sv
module stepper_xlat (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] mode,
  input  logic       dir_pin,
  input  logic       dir_inv,
  input  logic       run_pin,
  input  logic       run_inv,
  input  logic       step_in,
  output logic [5:0] pos,
  output logic [7:0] x_mag,
  output logic       x_neg,
  output logic [7:0] y_mag,
  output logic       y_neg
);

  logic [2:0] sync_q;
  logic [4:0] inc;
  logic [5:0] base;
  logic [3:0] frac;
  logic [7:0] sin_lo, sin_hi;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= 3'b000;
    else        sync_q <= {sync_q[1:0], step_in};

  wire edge_hit = sync_q[1] & ~sync_q[2];
  wire fwd      = dir_pin ^ dir_inv;
  wire running  = run_pin ^ run_inv;

  always_comb
    case (mode)
      3'd0:       inc = 5'd16;
      3'd1, 3'd5: inc = 5'd8;
      3'd2:       inc = 5'd4;
      3'd3:       inc = 5'd2;
      default:    inc = 5'd1;
    endcase

  assign base = pos & ~(6'({1'b0, inc}) - 6'd1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                  pos <= 6'd8;
    else if (edge_hit && running) pos <= fwd ? base + 6'({1'b0, inc}) : base - 6'({1'b0, inc});
    else                          pos <= base;

  function automatic logic [7:0] qwave(input logic [4:0] k);
    case (k)
      5'd0:  qwave = 8'd0;
      5'd1:  qwave = 8'd25;
      5'd2:  qwave = 8'd50;
      5'd3:  qwave = 8'd74;
      5'd4:  qwave = 8'd98;
      5'd5:  qwave = 8'd120;
      5'd6:  qwave = 8'd142;
      5'd7:  qwave = 8'd162;
      5'd8:  qwave = 8'd180;
      5'd9:  qwave = 8'd197;
      5'd10: qwave = 8'd212;
      5'd11: qwave = 8'd225;
      5'd12: qwave = 8'd236;
      5'd13: qwave = 8'd244;
      5'd14: qwave = 8'd250;
      5'd15: qwave = 8'd254;
      default: qwave = 8'd255;
    endcase
  endfunction

  assign frac   = pos[3:0];
  assign sin_lo = qwave({1'b0, frac});
  assign sin_hi = qwave(5'd16 - {1'b0, frac});

  wire boost = (mode == 3'd1) && (frac == 4'd8);

  assign y_mag = boost ? 8'd255 : (pos[4] ? sin_hi : sin_lo);
  assign x_mag = boost ? 8'd255 : (pos[4] ? sin_lo : sin_hi);
  assign y_neg = pos[5] && (y_mag != 8'd0);
  assign x_neg = (pos[5] ^ pos[4]) && (x_mag != 8'd0);

endmodule

// File: rtl/stepper_xlat_chk.sv
module stepper_xlat_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] mode,
  input logic       run_pin,
  input logic       run_inv,
  input logic [5:0] pos,
  input logic [7:0] x_mag,
  input logic [7:0] y_mag
);

  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;

  wire armed = (age == 2'd3);

  a_r1_reset_pos: assert property (@(posedge clk) $rose(rst_n) |-> pos == 6'd8);

  a_r3_unit_move: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(mode) == 3'd4 && $past(mode, 2) == 3'd4) |->
      (pos == $past(pos) || pos == 6'($past(pos) + 6'd1) || pos == 6'($past(pos) - 6'd1)));

  a_r5_full_grid: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(mode) == 3'd0) |-> pos[3:0] == 4'd0);

  a_r7_hold_still: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(mode) == $past(mode, 2) && !$past(run_pin ^ run_inv)) |-> pos == $past(pos));

  a_r8_axis_peak: assert property (@(posedge clk) disable iff (!rst_n)
    (x_mag == 8'd0) |-> (y_mag == 8'd255));

endmodule

bind stepper_xlat stepper_xlat_chk chk_i (
  .clk(clk), .rst_n(rst_n), .mode(mode), .run_pin(run_pin), .run_inv(run_inv),
  .pos(pos), .x_mag(x_mag), .y_mag(y_mag)
);

// File: tb/stepper_xlat_tb_top.sv
module stepper_xlat_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] mode = 3'd4;
  logic dir_pin = 1'b1, dir_inv = 1'b0, run_pin = 1'b1, run_inv = 1'b0, step_in = 1'b0;
  logic [5:0] pos;
  logic [7:0] x_mag, y_mag;
  logic x_neg, y_neg;

  int total = 0, bad = 0;
  int exp_pos = 8;
  bit done = 0;

  always #2 clk = ~clk;

  stepper_xlat dut_i (
    .clk(clk), .rst_n(rst_n), .mode(mode), .dir_pin(dir_pin), .dir_inv(dir_inv),
    .run_pin(run_pin), .run_inv(run_inv), .step_in(step_in),
    .pos(pos), .x_mag(x_mag), .x_neg(x_neg), .y_mag(y_mag), .y_neg(y_neg)
  );

  function automatic int inc_of(int m);
    case (m)
      0: return 16;
      1, 5: return 8;
      2: return 4;
      3: return 2;
      default: return 1;
    endcase
  endfunction

  function automatic real wave(int p, bit is_y);
    real a = p * 3.14159265358979 / 32.0;
    return is_y ? $sin(a) : $cos(a);
  endfunction

  function automatic int emag(int p, int m, bit is_y);
    real v = wave(p, is_y);
    if (m == 1 && p % 16 == 8) return 255;
    if (v < 0.0) v = -v;
    return $rtoi(255.0 * v + 0.5);
  endfunction

  function automatic int eneg(int p, bit is_y);
    return (wave(p, is_y) < -1.0e-6) ? 1 : 0;
  endfunction

  task automatic chk(string req, int got, int expv);
    total++;
    if (got != expv) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, expv);
    end
  endtask

  task automatic chk_all(string req);
    chk({req, " pos"}, int'(pos), exp_pos);
    chk({req, " R8 x_mag"}, int'(x_mag), emag(exp_pos, int'(mode), 1'b0));
    chk({req, " R8 y_mag"}, int'(y_mag), emag(exp_pos, int'(mode), 1'b1));
    chk({req, " R9 x_neg"}, int'(x_neg), eneg(exp_pos, 1'b0));
    chk({req, " R9 y_neg"}, int'(y_neg), eneg(exp_pos, 1'b1));
  endtask

  task automatic setm(int m);
    @(negedge clk);
    mode = 3'(m);
    exp_pos = exp_pos & ~(inc_of(m) - 1);
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse();
    @(negedge clk);
    step_in = 1'b1;
    repeat (4) @(negedge clk);
    step_in = 1'b0;
    repeat (4) @(negedge clk);
    if (run_pin ^ run_inv)
      exp_pos = (exp_pos + ((dir_pin ^ dir_inv) ? inc_of(int'(mode)) : 64 - inc_of(int'(mode)))) % 64;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset pos", int'(pos), 8);
    chk("R1 reset x_mag", int'(x_mag), 180);
    chk("R1 reset y_mag", int'(y_mag), 180);
    chk("R1 reset signs", int'({x_neg, y_neg}), 0);

    // R4 latency and single step per edge
    step_in = 1'b1;
    repeat (2) @(negedge clk);
    chk("R4 no move before third edge", int'(pos), 8);
    @(negedge clk);
    chk("R4 moved on third edge R3", int'(pos), 9);
    repeat (4) @(negedge clk);
    chk("R4 one step per edge", int'(pos), 9);
    step_in = 1'b0;
    repeat (4) @(negedge clk);
    exp_pos = 9;

    setm(0);
    chk("R5 coarsen clears low bits", int'(pos), 0);
    pulse(); chk("R2 full step up", int'(pos), 16);
    setm(4);
    chk("R6 finer keeps position", int'(pos), 16);

    run_pin = 1'b0;
    pulse(); chk("R7 hold ignores step", int'(pos), 16);
    run_inv = 1'b1;
    pulse(); chk("R7 xor run", int'(pos), 17);
    run_pin = 1'b1; run_inv = 1'b0;

    dir_inv = 1'b1;
    pulse(); chk("R3 xor direction down", int'(pos), 16);
    setm(0);
    pulse(); chk("R3 full down", int'(pos), 0);
    pulse(); chk("R3 wrap below zero", int'(pos), 48);
    chk_all("R9 quadrant 3");
    dir_inv = 1'b0;

    setm(4);
    repeat (8) pulse();
    chk("R3 sixteenth forward", int'(pos), 56);
    repeat (8) pulse();
    chk("R3 wrap past 63", int'(pos), 0);
    repeat (8) pulse();
    setm(1);
    chk("R10 half at diagonal x", int'(x_mag), 255);
    chk("R10 half at diagonal y", int'(y_mag), 255);
    setm(5);
    chk("R10 plain half at diagonal", int'(y_mag), 180);
    pulse(); chk("R2 mode 5 increment", int'(pos), 16);
    setm(6);
    pulse(); chk("R2 mode 6 as sixteenth", int'(pos), 17);
    setm(3);
    chk("R5 eighth clears bit0", int'(pos), 16);

    for (int i = 0; i < 400; i++) begin
      if ($urandom % 8 == 0) setm(int'($urandom % 8));
      dir_pin = 1'($urandom);
      dir_inv = 1'($urandom);
      run_pin = 1'($urandom);
      run_inv = ($urandom % 7 == 0) ? run_pin : ~run_pin;
      pulse();
      chk_all("R2 R3 R5 R7 random");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule